// File: doc/BRIEF.md
# Dual-Button Delayed Reset Supervisor

This block is a small reset supervisor for a product whose only reset path is a pair of ordinary keys. It drives an active-low reset output. A reset from the keys happens only when both key inputs are held low together, without a break, for a selectable qualification time. A short or lopsided press does nothing, so ordinary key use cannot reset the system by accident. A digital undervoltage flag from an external comparator, already synchronous to the clock, forces the reset output low at once. The output then stays low for a recovery time after the flag clears. The same recovery time is applied at power-up.

Time is measured in pulses of a slow tick enable, for example one per millisecond. The qualification times and the recovery time are parameters given in ticks. The reset pulse from the keys has one of two shapes. It can last a fixed recovery time, or it can last for as long as the keys stay held. An early-warning output is high while a qualifying press is being timed, so that firmware can save state before the reset arrives. A product with a single reset key wires that key to both inputs.

Top module: `dbrst_supervisor`

## Requirements
- R1: `rst_out_n` is active low. It is low while `rst_n` is low. After `rst_n` is released it stays low until the clock edge that carries the REC-th tick, counting from the first edge after the release, and then goes high.
- R2: When both key inputs (active low) have been low through the synchroniser, the qualification count starts on the next edge. `rst_out_n` goes low on the edge that carries the tick completing the selected number of ticks. With a tick on every cycle, this is 3 + L edges after both keys go low, where L is the selected count.
- R3: `dly_sel` picks the number of ticks to qualify: 0 gives T_SHORT, 1 gives T_MID, 2 gives T_LONG, and 3 also gives T_LONG.
- R4: If either key is released before the count completes, the count is dropped, `warn` falls, and no reset is produced.
- R5: If only one key is held low, however long, no count starts and no reset is produced.
- R6: With `held_mode` = 0, the key-triggered reset lasts exactly REC ticks after the edge on which it asserts, whatever the keys do in the meantime.
- R7: With `held_mode` = 1, the key-triggered reset lasts while both keys stay low. It ends 3 edges after either key is released.
- R8: After a key-triggered reset, no new count starts while both keys remain held. A key must be released and both pressed again first.
- R9: `uv_flag` high drives `rst_out_n` low on the next edge. `rst_out_n` goes high on the edge that carries the REC-th tick, counting from the first edge that sees the flag low.
- R10: `warn` is high from the edge on which counting starts until the edge on which the count completes or is dropped.
- R11: The count advances only on cycles where `tick` is high. With `tick` held low, a held press keeps `warn` high and never produces a reset.
- R12: With one key wired to both inputs, the block times that key exactly as it times two keys pressed together (R2 timing).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| tick | input | 1 | One-cycle time-base enable |
| btn_a_n | input | 1 | First key, active low, asynchronous |
| btn_b_n | input | 1 | Second key, active low, asynchronous |
| dly_sel | input | 2 | Qualification time select |
| held_mode | input | 1 | 0: fixed-length reset pulse, 1: reset held while keys are down |
| uv_flag | input | 1 | Undervoltage flag, high = supply low, synchronous to clk |
| rst_out_n | output | 1 | Reset output, active low |
| warn | output | 1 | High while a qualifying press is being timed |

## Verification
Each result has a fixed latency. A key change reaches the qualifier two edges after it is driven, and the qualifier reacts one edge later. So `warn` rises 3 edges after a press, and the reset asserts 3 + L edges after the press. A key release ends a held-mode reset 3 edges after it is driven. The undervoltage flag acts on the very next edge, and every recovery ends on the edge that carries the REC-th tick. The scoreboard driver converts each stimulus into expected items stamped with the exact cycle at which the output must hold its value. The monitor compares them at the falling edge of that cycle, and reports any item still queued after its cycle has passed as a failure.

// File: rtl/dbrst_pkg.sv
package dbrst_pkg;

   // qualifier state
   typedef enum logic [1:0] {
      Q_IDLE  = 2'd0,
      Q_COUNT = 2'd1,
      Q_LOCK  = 2'd2
   } qual_st_e;

   // reset pulse shape
   typedef enum logic {
      PULSE_FIXED = 1'b0,
      PULSE_HELD  = 1'b1
   } pulse_mode_e;

endpackage

// File: rtl/dbrst_sync.sv
module dbrst_sync #(
   parameter int          WIDTH     = 2,
   parameter int          STAGES    = 2,
   parameter logic        RESET_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[0] <= {WIDTH{RESET_VAL}};
      else        chain[0] <= d;
   end

   generate
      for (genvar s = 1; s < STAGES; s++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RESET_VAL}};
            else        chain[s] <= chain[s-1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/dbrst_hold_qual.sv
module dbrst_hold_qual
   import dbrst_pkg::*;
#(
   parameter int T_SHORT = 2000,
   parameter int T_MID   = 6000,
   parameter int T_LONG  = 10000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       both_low,
   input  logic [1:0] sel,
   output logic       counting,
   output logic       locked,
   output logic       fire
);

   localparam int CNT_W = $clog2(T_LONG + 1);

   qual_st_e         st_q, st_d;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic [CNT_W-1:0] limit;

   always_comb begin
      case (sel)
         2'd0:    limit = CNT_W'(T_SHORT);
         2'd1:    limit = CNT_W'(T_MID);
         default: limit = CNT_W'(T_LONG);
      endcase
   end

   // >= so that a smaller select mid-count still completes
   assign fire = (st_q == Q_COUNT) && both_low && tick &&
                 (cnt_q >= (limit - CNT_W'(1)));

   always_comb begin
      st_d  = st_q;
      cnt_d = cnt_q;
      case (st_q)
         Q_IDLE: begin
            if (both_low) begin
               st_d  = Q_COUNT;
               cnt_d = '0;
            end
         end
         Q_COUNT: begin
            if (!both_low)  st_d = Q_IDLE;
            else if (fire)  st_d = Q_LOCK;
            else if (tick)  cnt_d = cnt_q + CNT_W'(1);
         end
         Q_LOCK: begin
            if (!both_low) st_d = Q_IDLE;
         end
         default: st_d = Q_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= Q_IDLE;
         cnt_q <= '0;
      end else begin
         st_q  <= st_d;
         cnt_q <= cnt_d;
      end
   end

   assign counting = (st_q == Q_COUNT);
   assign locked   = (st_q == Q_LOCK);

endmodule

// File: rtl/dbrst_stretch.sv
module dbrst_stretch #(
   parameter int REC = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic tick,
   input  logic load,
   output logic busy_next
);

   localparam int             REC_W = $clog2(REC + 1);
   localparam logic [REC_W-1:0] REC_V = REC_W'(REC);

   logic [REC_W-1:0] rec_q, rec_d;

   always_comb begin
      if (load)                         rec_d = REC_V;
      else if (tick && (rec_q != '0))   rec_d = rec_q - REC_W'(1);
      else                              rec_d = rec_q;
   end

   // power-up starts a full recovery window
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rec_q <= REC_V;
      else        rec_q <= rec_d;
   end

   assign busy_next = (rec_d != '0);

endmodule

// File: rtl/dbrst_supervisor.sv
module dbrst_supervisor
   import dbrst_pkg::*;
#(
   parameter int T_SHORT     = 2000,
   parameter int T_MID       = 6000,
   parameter int T_LONG      = 10000,
   parameter int REC         = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       btn_a_n,
   input  logic       btn_b_n,
   input  logic [1:0] dly_sel,
   input  logic       held_mode,
   input  logic       uv_flag,
   output logic       rst_out_n,
   output logic       warn
);

   initial begin
      assert (T_SHORT >= 1 && T_SHORT <= T_MID && T_MID <= T_LONG)
         else $error("qualification times must be ordered and nonzero");
      assert (REC >= 1) else $error("recovery time must be nonzero");
      assert (SYNC_STAGES >= 2) else $error("synchroniser needs two stages");
   end

   logic [1:0]  btn_sync;
   logic        a_sync, b_sync, both_low;
   logic        counting, locked, fire;
   logic        rec_load, busy_next;
   logic        rst_q;
   pulse_mode_e mode;

   dbrst_sync #(
      .WIDTH     (2),
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({btn_b_n, btn_a_n}),
      .q     (btn_sync)
   );

   assign a_sync   = btn_sync[0];
   assign b_sync   = btn_sync[1];
   assign both_low = !a_sync && !b_sync;
   assign mode     = pulse_mode_e'(held_mode);

   dbrst_hold_qual #(
      .T_SHORT (T_SHORT),
      .T_MID   (T_MID),
      .T_LONG  (T_LONG)
   ) u_qual (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .both_low (both_low),
      .sel      (dly_sel),
      .counting (counting),
      .locked   (locked),
      .fire     (fire)
   );

   assign rec_load = uv_flag || (fire && (mode == PULSE_FIXED));

   dbrst_stretch #(
      .REC (REC)
   ) u_stretch (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .load      (rec_load),
      .busy_next (busy_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_q <= 1'b1;
      else        rst_q <= busy_next ||
                           ((mode == PULSE_HELD) && (fire || (locked && both_low)));
   end

   assign rst_out_n = !rst_q;
   assign warn      = counting;

endmodule

// File: rtl/dbrst_supervisor_chk.sv
module dbrst_supervisor_chk (
   input logic clk,
   input logic rst_n,
   input logic tick,
   input logic uv_flag,
   input logic held_mode,
   input logic rst_out_n,
   input logic warn,
   input logic a_sync,
   input logic b_sync,
   input logic fire
);

   p_uv_immediate_r9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag |=> !rst_out_n);

   p_no_release_under_uv_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_out_n) |-> !$past(uv_flag));

   p_warn_needs_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
      warn |-> ($past(!a_sync) && $past(!b_sync)));

   p_fire_asserts_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> (!warn && !rst_out_n));

   p_quiet_without_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_out_n && !tick && !uv_flag && !held_mode) |=> rst_out_n);

endmodule

bind dbrst_supervisor dbrst_supervisor_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick      (tick),
   .uv_flag   (uv_flag),
   .held_mode (held_mode),
   .rst_out_n (rst_out_n),
   .warn      (warn),
   .a_sync    (a_sync),
   .b_sync    (b_sync),
   .fire      (fire)
);

// File: tb/dbrst_supervisor_bench.sv
`timescale 1ns/1ps
module dbrst_supervisor_bench;

   localparam int T_SHORT = 4;
   localparam int T_MID   = 7;
   localparam int T_LONG  = 10;
   localparam int REC     = 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick;
   logic       btn_a_n;
   logic       btn_b_drv;
   logic       tie;
   logic       btn_b_n;
   logic [1:0] dly_sel;
   logic       held_mode;
   logic       uv_flag;
   logic       rst_out_n;
   logic       warn;

   int cyc = 0;
   int checks = 0;
   int fails = 0;
   bit done = 1'b0;

   typedef struct {
      int    at;
      logic  rst;
      logic  chk_warn;
      logic  wrn;
      string req;
   } exp_t;

   exp_t sbq[$];

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   assign btn_b_n = tie ? btn_a_n : btn_b_drv;

   dbrst_supervisor #(
      .T_SHORT (T_SHORT),
      .T_MID   (T_MID),
      .T_LONG  (T_LONG),
      .REC     (REC)
   ) u_dbrst_supervisor (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .btn_a_n   (btn_a_n),
      .btn_b_n   (btn_b_n),
      .dly_sel   (dly_sel),
      .held_mode (held_mode),
      .uv_flag   (uv_flag),
      .rst_out_n (rst_out_n),
      .warn      (warn)
   );

   task automatic expect_at(int at, logic r, logic cw, logic w, string req);
      exp_t e;
      e.at = at; e.rst = r; e.chk_warn = cw; e.wrn = w; e.req = req;
      sbq.push_back(e);
   endtask

   // monitor: compares each expected item at the falling edge of its cycle
   always @(negedge clk) begin
      exp_t item;
      while (sbq.size() > 0 && sbq[0].at <= cyc) begin
         item = sbq.pop_front();
         checks++;
         if (item.at < cyc) begin
            fails++;
            $display("FAIL %s: item for cycle %0d missed (now %0d)", item.req, item.at, cyc);
         end else if (rst_out_n !== item.rst) begin
            fails++;
            $display("FAIL %s: cycle %0d rst_out_n=%b expected %b", item.req, cyc, rst_out_n, item.rst);
         end
         if (item.at == cyc && item.chk_warn) begin
            checks++;
            if (warn !== item.wrn) begin
               fails++;
               $display("FAIL %s: cycle %0d warn=%b expected %b", item.req, cyc, warn, item.wrn);
            end
         end
      end
   end

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic drain();
      wait (sbq.size() == 0);
      @(negedge clk);
   endtask

   // both keys (or the tied key) held through a fixed-mode reset
   task automatic press_fixed(logic [1:0] sel, int l, string req);
      int c;
      dly_sel = sel;
      c = cyc;
      btn_a_n = 1'b0;
      if (!tie) btn_b_drv = 1'b0;
      expect_at(c + 2, 1'b1, 1'b1, 1'b0, "R10");
      expect_at(c + 3, 1'b1, 1'b1, 1'b1, "R10");
      expect_at(c + 2 + l, 1'b1, 1'b1, 1'b1, req);
      expect_at(c + 3 + l, 1'b0, 1'b1, 1'b0, req);
      expect_at(c + 2 + l + REC, 1'b0, 1'b0, 1'b0, "R6");
      expect_at(c + 3 + l + REC, 1'b1, 1'b0, 1'b0, "R6");
      expect_at(c + 7 + l + REC, 1'b1, 1'b1, 1'b0, "R8");
      idle(l + REC + 10);
      btn_a_n = 1'b1;
      btn_b_drv = 1'b1;
      idle(5);
      drain();
   endtask

   initial begin
      int c, r;
      rst_n = 1'b0; tick = 1'b1; btn_a_n = 1'b1; btn_b_drv = 1'b1; tie = 1'b0;
      dly_sel = 2'd0; held_mode = 1'b0; uv_flag = 1'b0;
      idle(3);

      // R1 power-up recovery
      c = cyc;
      expect_at(c + 1, 1'b0, 1'b1, 1'b0, "R1");
      expect_at(c + REC - 1, 1'b0, 1'b0, 1'b0, "R1");
      expect_at(c + REC, 1'b1, 1'b1, 1'b0, "R1");
      rst_n = 1'b1;
      idle(REC + 3);
      drain();

      // R2 / R3 per select code
      press_fixed(2'd0, T_SHORT, "R2");
      press_fixed(2'd1, T_MID, "R3");
      press_fixed(2'd2, T_LONG, "R3");
      press_fixed(2'd3, T_LONG, "R3");

      // R4 abort by releasing one key mid-count
      dly_sel = 2'd1;
      c = cyc;
      btn_a_n = 1'b0; btn_b_drv = 1'b0;
      expect_at(c + 4, 1'b1, 1'b1, 1'b1, "R4");
      expect_at(c + 6, 1'b1, 1'b1, 1'b0, "R4");
      expect_at(c + 12, 1'b1, 1'b1, 1'b0, "R4");
      expect_at(c + 17, 1'b1, 1'b1, 1'b0, "R4");
      idle(3);
      btn_a_n = 1'b1;
      idle(15);
      btn_b_drv = 1'b1;
      idle(4);
      drain();

      // R5 only one key held
      dly_sel = 2'd0;
      c = cyc;
      btn_a_n = 1'b0;
      expect_at(c + 4, 1'b1, 1'b1, 1'b0, "R5");
      expect_at(c + 20, 1'b1, 1'b1, 1'b0, "R5");
      idle(22);
      btn_a_n = 1'b1;
      idle(4);
      drain();

      // R12 single key wired to both inputs
      tie = 1'b1;
      press_fixed(2'd1, T_MID, "R12");
      tie = 1'b0;

      // R7 held mode
      held_mode = 1'b1;
      dly_sel = 2'd0;
      c = cyc;
      btn_a_n = 1'b0; btn_b_drv = 1'b0;
      expect_at(c + 3, 1'b1, 1'b1, 1'b1, "R7");
      expect_at(c + 3 + T_SHORT, 1'b0, 1'b1, 1'b0, "R7");
      expect_at(c + 15, 1'b0, 1'b0, 1'b0, "R7");
      idle(17);
      r = cyc;
      expect_at(r + 2, 1'b0, 1'b0, 1'b0, "R7");
      expect_at(r + 3, 1'b1, 1'b1, 1'b0, "R7");
      btn_b_drv = 1'b1;
      idle(5);
      btn_a_n = 1'b1;
      idle(4);
      drain();
      held_mode = 1'b0;

      // R9 undervoltage
      c = cyc;
      uv_flag = 1'b1;
      expect_at(c + 1, 1'b0, 1'b0, 1'b0, "R9");
      idle(6);
      r = cyc;
      uv_flag = 1'b0;
      expect_at(r + REC - 1, 1'b0, 1'b0, 1'b0, "R9");
      expect_at(r + REC, 1'b1, 1'b0, 1'b0, "R9");
      idle(REC + 3);
      drain();

      // R11 no count without ticks, then resume
      tick = 1'b0;
      dly_sel = 2'd0;
      c = cyc;
      btn_a_n = 1'b0; btn_b_drv = 1'b0;
      expect_at(c + 3, 1'b1, 1'b1, 1'b1, "R11");
      expect_at(c + 30, 1'b1, 1'b1, 1'b1, "R11");
      idle(31);
      r = cyc;
      tick = 1'b1;
      expect_at(r + T_SHORT - 1, 1'b1, 1'b1, 1'b1, "R11");
      expect_at(r + T_SHORT, 1'b0, 1'b1, 1'b0, "R11");
      idle(T_SHORT + REC + 4);
      btn_a_n = 1'b1; btn_b_drv = 1'b1;
      idle(5);
      drain();

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, %0d items pending, expected 0", sbq.size());
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

endmodule